// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of an 8-bit parallel flash bus. It drives that bus to program one byte, to erase one or more sectors, or to erase the whole chip. A request carries the operation code, a target address, a data byte and a list of sector addresses. The request is taken on a valid/ready handshake.

The block first emits the unlock and command write cycles the flash expects. It then polls the device with pairs of status reads until the toggling status bit settles. It finishes with a one-cycle done pulse and a fail flag. When a failure is found, it writes the reset command before it reports.

Every bus cycle comes from a small phase counter. The counter walks through an address/data setup phase, a strobe-low phase and a hold phase. The lengths of all three phases are parameters counted in system clock cycles.

Top module: `flash_pe_seq`

## Requirements
- R1: After reset, reqReady is 1, flCeN, flOeN and flWeN are 1, and doneValid is 0.
- R2: A program request (reqOp 0) emits exactly four writes: AAh at 555h, 55h at 2AAh, A0h at 555h, then reqData at reqAddr.
- R3: A chip erase request (reqOp 2, and 3 behaves the same) emits six writes: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h.
- R4: A sector erase request (reqOp 1) emits the first five writes of R3 and then 30h at the first listed sector (list slot 0 is reqSect[16:0]). For each further sector, up to reqSectNum sectors, the block does three things in order: a status read, a write of 30h at that sector, and a second status read. Status bit 3 reading 1 in either read is a failure.
- R5: On every write, flWeN stays low for exactly PULSE_CYC clock cycles. flAddr and flDout do not change while flWeN is low, and they are still unchanged at the cycle in which flWeN rises. Address and data are driven SETUP_CYC cycles before the strobe falls.
- R6: Polling reads the device twice. If status bit 6 is the same in both reads, the operation has completed and doneFail is 0 (after the readback of R9 for a program).
- R7: If bit 6 differs and bit 5 of the second read is 1, the block reads twice more. If bit 6 is now equal, it reports success. If bit 6 still differs, it reports failure. If bit 6 differs and bit 5 is 0, polling goes on.
- R8: Every failure writes F0h at address 0 as the last bus write, and only then raises doneValid with doneFail set.
- R9: After a program has completed, the block reads reqAddr once. A byte different from reqData is a failure.
- R10: If POLL_LIMIT read pairs go by with bit 6 changing and bit 5 at 0, the block reports a failure.
- R11: reqReady drops in the cycle after a request is accepted. doneValid is high for exactly one cycle per request.
- R12: flWeN and flOeN are never low together, and neither is low while flCeN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle and able to take a request |
| reqOp | input | 2 | 0 program, 1 sector erase, 2 or 3 chip erase |
| reqAddr | input | 17 | Program address; also used for the polling reads |
| reqData | input | 8 | Byte to program |
| reqSect | input | 68 | Four sector addresses; slot i sits at bits [17*i +: 17] |
| reqSectNum | input | 3 | Number of sectors to erase, clamped to 1..4 |
| doneValid | output | 1 | One-cycle completion pulse |
| doneFail | output | 1 | Outcome; valid with doneValid |
| flAddr | output | 17 | Flash address bus |
| flDout | output | 8 | Data driven to the flash |
| flDin | input | 8 | Data read from the flash |
| flDoe | output | 1 | Output enable for the data bus pads |
| flCeN | output | 1 | Chip enable, active low |
| flOeN | output | 1 | Read strobe, active low |
| flWeN | output | 1 | Write strobe, active low |

## Verification
The assertions assume three things about the block's inputs:
- flDin is steady during the last cycle of a read strobe.
- The request fields stay fixed while reqValid waits for reqReady.
- The flash toggles bit 6 only between separate read strobes.

The bench's flash model keeps to all three. It updates its status only on a detected rising edge of flOeN or flWeN. The bench changes request fields only on falling clock edges, and only while the block is idle.

Through its mode setting, the model covers these cases:
- normal completion;
- a bit-5 timeout;
- bit 5 arriving on the very read where toggling stops;
- a readback mismatch;
- an early-closed sector window;
- a device that never finishes.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_CHIP_ALT = 2'd3
  } flashOpE;

  typedef enum logic [2:0] {
    AS_555  = 3'd0,
    AS_2AA  = 3'd1,
    AS_REQ  = 3'd2,
    AS_SECT = 3'd3,
    AS_ZERO = 3'd4
  } addrSelE;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;        // capture request fields
    logic       go;          // start one bus cycle
    logic       rd;          // bus cycle is a read
    addrSelE    aSel;        // address source
    logic       useReqData;  // drive request byte instead of cmd
    logic [7:0] cmd;         // command byte
    logic       sectAdv;     // step to next listed sector
  } dpCtlT;

  localparam logic [7:0] CMD_UNLK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLK_B = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_RESET  = 8'hF0;

endpackage

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int MAX_SECT  = 4,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 2,
  localparam int SN_W = $clog2(MAX_SECT + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtlT                      ctl,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic [7:0]                 reqData,
  input  logic [MAX_SECT*ADDR_W-1:0] reqSect,
  input  logic [SN_W-1:0]            reqSectNum,
  output logic                       busIdle,
  output logic                       busDone,
  output logic                       statTog,
  output logic                       statLim,
  output logic                       statWin,
  output logic                       rdMatch,
  output logic                       sectLast,
  output logic [ADDR_W-1:0]          flAddr,
  output logic [7:0]                 flDout,
  input  logic [7:0]                 flDin,
  output logic                       flDoe,
  output logic                       flCeN,
  output logic                       flOeN,
  output logic                       flWeN
);

  localparam int SI_W = (MAX_SECT > 1) ? $clog2(MAX_SECT) : 1;
  localparam int MAXC = (SETUP_CYC > PULSE_CYC)
                        ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                        : ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phaseE;

  phaseE             phase;
  logic [CNT_W-1:0]  phCnt;
  logic              opRd;
  logic [ADDR_W-1:0] busAddr;
  logic [7:0]        busData;
  logic [7:0]        rdData;

  logic [ADDR_W-1:0] addrR;
  logic [7:0]        dataR;
  logic [ADDR_W-1:0] sectR [MAX_SECT];
  logic [SN_W-1:0]   sectCnt;
  logic [SI_W-1:0]   sectIdx;

  logic [ADDR_W-1:0] selAddr;
  logic [7:0]        selData;

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR   <= '0;
      dataR   <= '0;
      sectCnt <= SN_W'(1);
      sectIdx <= '0;
    end else if (ctl.load) begin
      addrR   <= reqAddr;
      dataR   <= reqData;
      sectIdx <= '0;
      if (reqSectNum == '0)
        sectCnt <= SN_W'(1);
      else if (reqSectNum > SN_W'(MAX_SECT))
        sectCnt <= SN_W'(MAX_SECT);
      else
        sectCnt <= reqSectNum;
    end else if (ctl.sectAdv && !sectLast) begin
      sectIdx <= sectIdx + SI_W'(1);
    end
  end

  for (genvar g = 0; g < MAX_SECT; g++) begin : gSect
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        sectR[g] <= '0;
      else if (ctl.load)
        sectR[g] <= reqSect[g*ADDR_W +: ADDR_W];
    end
  end

  assign sectLast = (SN_W'(sectIdx) + SN_W'(1)) >= sectCnt;

  always_comb begin
    case (ctl.aSel)
      AS_555:  selAddr = ADDR_W'(11'h555);
      AS_2AA:  selAddr = ADDR_W'(11'h2AA);
      AS_REQ:  selAddr = addrR;
      AS_SECT: selAddr = sectR[sectIdx];
      default: selAddr = '0;
    endcase
    selData = ctl.useReqData ? dataR : ctl.cmd;
  end

  // bus cycle engine
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      phCnt   <= '0;
      opRd    <= 1'b0;
      busAddr <= '0;
      busData <= '0;
      rdData  <= '0;
      busDone <= 1'b0;
    end else begin
      busDone <= 1'b0;
      case (phase)
        PH_IDLE: if (ctl.go) begin
          busAddr <= selAddr;
          busData <= selData;
          opRd    <= ctl.rd;
          phCnt   <= CNT_W'(SETUP_CYC - 1);
          phase   <= PH_SETUP;
        end
        PH_SETUP: if (phCnt == '0) begin
          phCnt <= CNT_W'(PULSE_CYC - 1);
          phase <= PH_PULSE;
        end else phCnt <= phCnt - CNT_W'(1);
        PH_PULSE: if (phCnt == '0) begin
          if (opRd) rdData <= flDin;
          phCnt <= CNT_W'(HOLD_CYC - 1);
          phase <= PH_HOLD;
        end else phCnt <= phCnt - CNT_W'(1);
        default: if (phCnt == '0) begin
          phase   <= PH_IDLE;
          busDone <= 1'b1;
        end else phCnt <= phCnt - CNT_W'(1);
      endcase
    end
  end

  assign busIdle = (phase == PH_IDLE);
  assign flCeN   = (phase == PH_IDLE);
  assign flWeN   = !((phase == PH_PULSE) && !opRd);
  assign flOeN   = !((phase == PH_PULSE) && opRd);
  assign flDoe   = (phase != PH_IDLE) && !opRd;
  assign flAddr  = busAddr;
  assign flDout  = busData;

  assign statTog = rdData[6];
  assign statLim = rdData[5];
  assign statWin = rdData[3];
  assign rdMatch = (rdData == dataR);

  // strobe-low length tracker for the pulse-width check
  logic [CNT_W:0] weLowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      weLowCnt <= '0;
    else if (!flWeN)
      weLowCnt <= (weLowCnt == '1) ? weLowCnt : weLowCnt + 1'b1;
    else
      weLowCnt <= '0;
  end

  AST_WE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!flWeN && $past(!flWeN)) |-> ($stable(flAddr) && $stable(flDout))); // R5
  AST_WE_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flWeN) |-> ($stable(flAddr) && $stable(flDout) && !flCeN)); // R5
  AST_WE_MIN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flWeN) |-> (weLowCnt >= (CNT_W+1)'(PULSE_CYC))); // R5

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int POLL_LIMIT = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic [1:0] reqOp,
  input  logic       busIdle,
  input  logic       busDone,
  input  logic       statTog,
  input  logic       statLim,
  input  logic       statWin,
  input  logic       rdMatch,
  input  logic       sectLast,
  output dpCtlT      ctl,
  output logic       doneValid,
  output logic       doneFail
);

  localparam int PC_W = $clog2(POLL_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SEQ, S_CHK0, S_XWR, S_CHK1, S_POLLA, S_POLLB,
    S_POLLC, S_POLLD, S_VERIFY, S_RESET, S_DONE
  } stateE;

  stateE           state;
  flashOpE         opR;
  logic [2:0]      step;
  logic            waitBus;
  logic            prevTog;
  logic            failR;
  logic [PC_W-1:0] pollCnt;

  logic busState, issue, done, seqLast, togSame;

  assign busState = (state != S_IDLE) && (state != S_DONE);
  assign issue    = busState && !waitBus && busIdle;
  assign done     = waitBus && busDone;
  assign seqLast  = (opR == OP_PROG) ? (step == 3'd3) : (step == 3'd5);
  assign togSame  = (statTog == prevTog);
  assign reqReady = (state == S_IDLE);
  assign doneValid = (state == S_DONE);
  assign doneFail  = failR;

  always_comb begin
    ctl = '0;
    ctl.load = reqValid && reqReady;
    ctl.go   = issue;
    ctl.aSel = AS_555;
    case (state)
      S_SEQ: begin
        case (step)
          3'd0: begin ctl.aSel = AS_555; ctl.cmd = CMD_UNLK_A; end
          3'd1: begin ctl.aSel = AS_2AA; ctl.cmd = CMD_UNLK_B; end
          3'd2: begin
            ctl.aSel = AS_555;
            ctl.cmd  = (opR == OP_PROG) ? CMD_PROG : CMD_ERASE;
          end
          3'd3: begin
            if (opR == OP_PROG) begin
              ctl.aSel = AS_REQ; ctl.useReqData = 1'b1;
            end else begin
              ctl.aSel = AS_555; ctl.cmd = CMD_UNLK_A;
            end
          end
          3'd4: begin ctl.aSel = AS_2AA; ctl.cmd = CMD_UNLK_B; end
          default: begin
            if (opR == OP_SECT) begin
              ctl.aSel = AS_SECT; ctl.cmd = CMD_SECT;
            end else begin
              ctl.aSel = AS_555; ctl.cmd = CMD_CHIP;
            end
          end
        endcase
      end
      S_CHK0, S_CHK1: begin ctl.rd = 1'b1; ctl.aSel = AS_SECT; end
      S_XWR:          begin ctl.aSel = AS_SECT; ctl.cmd = CMD_SECT; end
      S_POLLA, S_POLLB, S_POLLC, S_POLLD, S_VERIFY: begin
        ctl.rd = 1'b1; ctl.aSel = AS_REQ;
      end
      S_RESET:        begin ctl.aSel = AS_ZERO; ctl.cmd = CMD_RESET; end
      default: ;
    endcase
    ctl.sectAdv = done && !sectLast &&
                  (((state == S_SEQ) && seqLast && (opR == OP_SECT)) ||
                   ((state == S_CHK1) && !statWin));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opR     <= OP_PROG;
      step    <= '0;
      waitBus <= 1'b0;
      prevTog <= 1'b0;
      failR   <= 1'b0;
      pollCnt <= '0;
    end else begin
      if (issue) waitBus <= 1'b1;
      else if (done) waitBus <= 1'b0;
      case (state)
        S_IDLE: if (reqValid) begin
          opR     <= flashOpE'(reqOp);
          step    <= '0;
          failR   <= 1'b0;
          pollCnt <= '0;
          state   <= S_SEQ;
        end
        S_SEQ: if (done) begin
          if (seqLast)
            state <= ((opR == OP_SECT) && !sectLast) ? S_CHK0 : S_POLLA;
          else
            step <= step + 3'd1;
        end
        S_CHK0: if (done) begin
          if (statWin) begin failR <= 1'b1; state <= S_RESET; end
          else state <= S_XWR;
        end
        S_XWR: if (done) state <= S_CHK1;
        S_CHK1: if (done) begin
          if (statWin) begin failR <= 1'b1; state <= S_RESET; end
          else state <= sectLast ? S_POLLA : S_CHK0;
        end
        S_POLLA: if (done) begin prevTog <= statTog; state <= S_POLLB; end
        S_POLLB: if (done) begin
          if (togSame)
            state <= (opR == OP_PROG) ? S_VERIFY : S_DONE;
          else if (statLim)
            state <= S_POLLC;
          else if (pollCnt == PC_W'(POLL_LIMIT - 1)) begin
            failR <= 1'b1; state <= S_RESET;
          end else begin
            pollCnt <= pollCnt + PC_W'(1);
            state   <= S_POLLA;
          end
        end
        S_POLLC: if (done) begin prevTog <= statTog; state <= S_POLLD; end
        S_POLLD: if (done) begin
          if (togSame) state <= (opR == OP_PROG) ? S_VERIFY : S_DONE;
          else begin failR <= 1'b1; state <= S_RESET; end
        end
        S_VERIFY: if (done) begin
          if (rdMatch) state <= S_DONE;
          else begin failR <= 1'b1; state <= S_RESET; end
        end
        S_RESET: if (done) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R11
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R11
  AST_FAIL_AFTER_RESET_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneFail) |-> ($past(state) == S_RESET)); // R8
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < PC_W'(POLL_LIMIT)); // R10

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int MAX_SECT   = 4,
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 3,
  parameter int HOLD_CYC   = 2,
  parameter int POLL_LIMIT = 64,
  localparam int SN_W = $clog2(MAX_SECT + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  output logic                       reqReady,
  input  logic [1:0]                 reqOp,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic [7:0]                 reqData,
  input  logic [MAX_SECT*ADDR_W-1:0] reqSect,
  input  logic [SN_W-1:0]            reqSectNum,
  output logic                       doneValid,
  output logic                       doneFail,
  output logic [ADDR_W-1:0]          flAddr,
  output logic [7:0]                 flDout,
  input  logic [7:0]                 flDin,
  output logic                       flDoe,
  output logic                       flCeN,
  output logic                       flOeN,
  output logic                       flWeN
);

  dpCtlT ctl;
  logic busIdle, busDone, statTog, statLim, statWin, rdMatch, sectLast;

  flash_seq_ctrl #(.POLL_LIMIT(POLL_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .busIdle(busIdle), .busDone(busDone),
    .statTog(statTog), .statLim(statLim), .statWin(statWin),
    .rdMatch(rdMatch), .sectLast(sectLast), .ctl(ctl),
    .doneValid(doneValid), .doneFail(doneFail)
  );

  flash_seq_dp #(
    .ADDR_W(ADDR_W), .MAX_SECT(MAX_SECT), .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqData(reqData),
    .reqSect(reqSect), .reqSectNum(reqSectNum), .busIdle(busIdle),
    .busDone(busDone), .statTog(statTog), .statLim(statLim),
    .statWin(statWin), .rdMatch(rdMatch), .sectLast(sectLast),
    .flAddr(flAddr), .flDout(flDout), .flDin(flDin), .flDoe(flDoe),
    .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN)
  );

endmodule

// File: tb/flash_pe_seq_bench.sv
module flash_pe_seq_bench;

  localparam int PULSE_CYC = 3;
  localparam logic [2:0] M_OK = 3'd0, M_FAIL = 3'd1, M_B5STOP = 3'd2,
                         M_BADRB = 3'd3, M_B3 = 3'd4, M_HANG = 3'd5;
  localparam logic [16:0] S0 = 17'h02000, S1 = 17'h04000,
                          S2 = 17'h10000, S3 = 17'h1C000;

  typedef struct packed {
    logic [1:0]  op;
    logic [16:0] addr;
    logic [7:0]  data;
    logic [2:0]  nsect;
    logic [2:0]  mode;
    logic [7:0]  busy;
    logic        expFail;
    logic [3:0]  expWr;
  } vecT;

  localparam int NV = 11;
  localparam vecT VECS [NV] = '{
    '{2'd0, 17'h12345, 8'h5A, 3'd1, M_OK,     8'd5,  1'b0, 4'd4},
    '{2'd0, 17'h00FF0, 8'hA3, 3'd1, M_OK,     8'd0,  1'b0, 4'd4},
    '{2'd2, 17'h00000, 8'h00, 3'd1, M_OK,     8'd9,  1'b0, 4'd6},
    '{2'd1, 17'h02000, 8'h00, 3'd1, M_OK,     8'd4,  1'b0, 4'd6},
    '{2'd1, 17'h02000, 8'h00, 3'd3, M_OK,     8'd12, 1'b0, 4'd8},
    '{2'd0, 17'h0A0A0, 8'h3C, 3'd1, M_FAIL,   8'd3,  1'b1, 4'd5},
    '{2'd1, 17'h02000, 8'h00, 3'd1, M_B5STOP, 8'd6,  1'b0, 4'd6},
    '{2'd0, 17'h1FFFF, 8'h81, 3'd1, M_BADRB,  8'd2,  1'b1, 4'd5},
    '{2'd1, 17'h02000, 8'h00, 3'd2, M_B3,     8'd4,  1'b1, 4'd7},
    '{2'd2, 17'h00000, 8'h00, 3'd1, M_HANG,   8'd0,  1'b1, 4'd7},
    '{2'd2, 17'h00000, 8'h00, 3'd1, M_FAIL,   8'd1,  1'b1, 4'd7}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [1:0] reqOp = '0;
  logic [16:0] reqAddr = '0;
  logic [7:0] reqData = '0;
  logic [67:0] reqSect = {S3, S2, S1, S0};
  logic [2:0] reqSectNum = 3'd1;
  logic doneValid, doneFail;
  logic [16:0] flAddr;
  logic [7:0] flDout, flDin;
  logic flDoe, flCeN, flOeN, flWeN;

  always #10 clk = ~clk;

  flash_pe_seq u_flash_pe_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData), .reqSect(reqSect),
    .reqSectNum(reqSectNum), .doneValid(doneValid), .doneFail(doneFail),
    .flAddr(flAddr), .flDout(flDout), .flDin(flDin), .flDoe(flDoe),
    .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN)
  );

  int nChecks = 0;
  int nFail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flash model
  logic [2:0] curMode = M_OK;
  logic [7:0] curBusy = '0;
  logic clrLog = 1'b1;
  int mWrCnt;
  logic [16:0] mLogA [16];
  logic [7:0]  mLogD [16];
  logic mBusy, mTog, mB5, mProg, prevWe, prevOe;
  logic [7:0] mMem;
  int mLeft;

  always_comb begin
    if (mBusy)
      flDin = {1'b0, mTog, mB5 || (curMode == M_B5STOP && mLeft == 1),
               1'b0, curMode == M_B3, 3'b000};
    else
      flDin = mProg ? mMem : 8'hFF;
  end

  always @(posedge clk) begin
    prevWe <= flWeN;
    prevOe <= flOeN;
    if (clrLog) begin
      mWrCnt <= 0; mBusy <= 1'b0; mB5 <= 1'b0; mProg <= 1'b0;
      mTog <= 1'b0; mLeft <= 0; mMem <= 8'hFF;
    end else begin
      if (!prevWe && flWeN && !flCeN) begin
        mLogA[mWrCnt[3:0]] <= flAddr;
        mLogD[mWrCnt[3:0]] <= flDout;
        mWrCnt <= mWrCnt + 1;
        if (flDout == 8'hF0) begin
          mBusy <= 1'b0; mB5 <= 1'b0;
        end else if ((mWrCnt == 3 && mLogD[2] == 8'hA0) ||
                     (mWrCnt == 5 && mLogD[2] == 8'h80)) begin
          if (mWrCnt == 3) begin
            mProg <= 1'b1;
            mMem  <= (curMode == M_BADRB) ? (flDout ^ 8'h01) : flDout;
          end
          if (curMode == M_HANG || curBusy != 0) begin
            mBusy <= 1'b1; mLeft <= int'(curBusy); mTog <= 1'b0; mB5 <= 1'b0;
          end
        end
      end
      if (!prevOe && flOeN && mBusy) begin
        mTog <= ~mTog;
        if (curMode == M_FAIL) begin
          if (mLeft > 1) mLeft <= mLeft - 1;
          else mB5 <= 1'b1;
        end else if (curMode != M_HANG) begin
          if (mLeft <= 1) mBusy <= 1'b0;
          else mLeft <= mLeft - 1;
        end
      end
    end
  end

  // bus timing monitor
  int lowCnt = 0;
  logic [16:0] addrAtFall;
  logic [7:0] dataAtFall;
  bit unstable = 0;
  bit exclSeen = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if ((!flWeN && !flOeN) || (flCeN && (!flWeN || !flOeN))) exclSeen = 1;
      if (!flWeN) begin
        if (lowCnt == 0) begin
          addrAtFall = flAddr; dataAtFall = flDout; unstable = 0;
        end else if (flAddr != addrAtFall || flDout != dataAtFall) unstable = 1;
        lowCnt++;
      end else if (lowCnt != 0) begin
        chk(lowCnt == PULSE_CYC && !unstable && flAddr == addrAtFall,
            "R5", "write strobe width/stability", lowCnt, PULSE_CYC);
        lowCnt = 0;
      end
    end
  end

  function automatic string modeReq(input logic [2:0] m);
    case (m)
      M_FAIL, M_B5STOP: return "R7";
      M_BADRB:          return "R9";
      M_B3:             return "R4";
      M_HANG:           return "R10";
      default:          return "R6";
    endcase
  endfunction

  function automatic string opReq(input logic [1:0] op);
    case (op)
      2'd0:    return "R2";
      2'd1:    return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic runVec(input vecT v);
    bit gotFail;
    int guard;
    string oq;
    oq = opReq(v.op);
    @(negedge clk);
    curMode = v.mode; curBusy = v.busy; clrLog = 1'b1;
    @(negedge clk);
    clrLog = 1'b0;
    reqOp = v.op; reqAddr = v.addr; reqData = v.data; reqSectNum = v.nsect;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R11", "ready after accept", reqReady, 0);
    guard = 0;
    while (!doneValid && guard < 20000) begin
      @(negedge clk); guard++;
    end
    gotFail = doneFail;
    @(negedge clk);
    chk(doneValid == 1'b0, "R11", "done pulse width", doneValid, 0);
    chk(gotFail == v.expFail, modeReq(v.mode), "fail flag", gotFail, v.expFail);
    chk(mWrCnt == int'(v.expWr), oq, "write count", mWrCnt, v.expWr);
    chk(mLogA[0] == 17'h555 && mLogD[0] == 8'hAA, oq, "first unlock",
        {mLogA[0], mLogD[0]}, {17'h555, 8'hAA});
    chk(mLogA[1] == 17'h2AA && mLogD[1] == 8'h55, oq, "second unlock",
        {mLogA[1], mLogD[1]}, {17'h2AA, 8'h55});
    chk(mLogD[2] == ((v.op == 2'd0) ? 8'hA0 : 8'h80), oq, "setup byte",
        mLogD[2], (v.op == 2'd0) ? 8'hA0 : 8'h80);
    if (v.op == 2'd0)
      chk(mLogA[3] == v.addr && mLogD[3] == v.data, "R2", "data write",
          {mLogA[3], mLogD[3]}, {v.addr, v.data});
    else if (v.op == 2'd1)
      chk(mLogA[5] == S0 && mLogD[5] == 8'h30, "R4", "first sector write",
          {mLogA[5], mLogD[5]}, {S0, 8'h30});
    else
      chk(mLogA[5] == 17'h555 && mLogD[5] == 8'h10, "R3", "chip erase byte",
          {mLogA[5], mLogD[5]}, {17'h555, 8'h10});
    if (v.op == 2'd1 && (int'(v.expWr) - int'(v.expFail)) > 6)
      chk(mLogA[6] == S1 && mLogD[6] == 8'h30, "R4", "extra sector write",
          {mLogA[6], mLogD[6]}, {S1, 8'h30});
    if (v.expFail)
      chk(mLogD[v.expWr - 1] == 8'hF0 && mLogA[v.expWr - 1] == 17'h0, "R8",
          "reset write last", mLogD[v.expWr - 1], 8'hF0);
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);
    chk(flCeN && flOeN && flWeN, "R1", "strobes idle after reset",
        {flCeN, flOeN, flWeN}, 3'b111);
    chk(doneValid == 1'b0, "R1", "doneValid after reset", doneValid, 0);
    for (int i = 0; i < NV; i++) runVec(VECS[i]);
    chk(!exclSeen, "R12", "strobe exclusivity", exclSeen, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog run did not finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule